// File: doc/BRIEF.md
# Magic-Sequence Register Unlock Gate

This block sits on the cartridge side of a host bus and watches single-cycle 16-bit host writes, each carrying a full address and a data word. Three control registers live behind a gate: a flash lock register, a flash enable register and a global-enable flag. The gate opens only after the host writes an exact run of four address/value pairs in order. It stays open until the host writes a closing value to a closing address. Control writes made while the gate is shut are dropped.

The usual host pattern is: arm the gate, make one control write, then close it. The flash enable register drives an active-low chip-enable pin from bit 0 and an active-low write-protect pin from bit 1. The lock register decides whether the host's flash command, address and data strobes reach the flash or are held low. All state is cleared by a synchronous active-high reset. The flash device, bus timing and any clock-chip logic are outside this block.

Top module: `magic_unlock_gate`

## Requirements
- R1: After a synchronous reset, gate_open = 0, flash_unlocked = 0, en_bits = 0 (so flash_ce_n = 0 and flash_wp_n = 0) and global_en = 0.
- R2: The gate opens (gate_open reads 1 from the cycle after the fourth write) after these writes in order: 0xD200 to 0x09FE0000, 0x1500 to 0x08000000, 0xD200 to 0x08020000, 0x1500 to 0x08040000.
- R3: A write to a decoded address that is not the next expected arming step sends the arming progress back to the start. A write of 0xD200 to 0x09FE0000 always counts as the first step, even in the middle of a run.
- R4: Writes to addresses outside the decoded set leave the arming progress, the gate and every register unchanged, even when they fall between arming steps. The decoded set is the five arming/closing addresses plus 0x09C40000, 0x09400000 and 0x09880000.
- R5: A write of 0x1500 to 0x09FC0000 closes the gate from the next cycle. Any other value written to that address leaves the gate open.
- R6: While the gate is open, writing 0x1500 to 0x09C40000 sets flash_unlocked to 1 and writing 0xD200 clears it. Other values leave it unchanged.
- R7: While the gate is open, a write to 0x09400000 stores data bits [1:0] in en_bits. flash_ce_n follows bit 0 and flash_wp_n follows bit 1, so value 0 gives 0/0, value 1 gives 1/0 and value 3 gives 1/1.
- R8: While the gate is open, writing 0x8000 to 0x09880000 sets global_en. Other values have no effect, and only reset clears the flag.
- R9: flash_stb equals host_stb in the same cycle while flash_unlocked is 1, and is all zero otherwise. Bit 0 is the command strobe, bit 1 the address strobe and bit 2 the data strobe.
- R10: Writes to the three control addresses while the gate is closed change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write valid this cycle |
| wr_addr | input | 32 | Host write address |
| wr_data | input | 16 | Host write data |
| host_stb | input | 3 | Host flash strobes {data, address, command} |
| gate_open | output | 1 | Control registers currently writable |
| flash_unlocked | output | 1 | Flash lock register state (1 = unlocked) |
| en_bits | output | 2 | Flash enable register |
| flash_ce_n | output | 1 | Active-low flash chip enable |
| flash_wp_n | output | 1 | Active-low flash write protect |
| global_en | output | 1 | Global-enable flag |
| flash_stb | output | 3 | Strobes forwarded to the flash |

## Verification
Wrong arming progress is invisible at the ports until it changes whether the gate opens. It therefore shows up one cycle after the fourth arming write of a run that interleaves resets, restarts and foreign-address writes. A control register that takes a write while the gate is shut, or misses one while it is open, shows on its output one cycle after that write. A wrong lock state shows on the forwarded strobes in the same cycle as the next strobe. The reference model compares every output on every clock, so each of these shows up within a single cycle of the write that exposes it.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 16;
  localparam int SEQ_LEN = 4;
  localparam int STEP_W = $clog2(SEQ_LEN);

  localparam logic [ADDR_W-1:0] A_CLOSE  = 32'h09FC_0000;
  localparam logic [ADDR_W-1:0] A_LOCK   = 32'h09C4_0000;
  localparam logic [ADDR_W-1:0] A_ENABLE = 32'h0940_0000;
  localparam logic [ADDR_W-1:0] A_GLOBAL = 32'h0988_0000;

  localparam logic [DATA_W-1:0] V_HI  = 16'hD200;
  localparam logic [DATA_W-1:0] V_LO  = 16'h1500;
  localparam logic [DATA_W-1:0] V_GEN = 16'h8000;

  // address expected at a given arming step
  function automatic logic [ADDR_W-1:0] step_addr(input logic [STEP_W-1:0] s);
    case (s)
      2'd0:    step_addr = 32'h09FE_0000;
      2'd1:    step_addr = 32'h0800_0000;
      2'd2:    step_addr = 32'h0802_0000;
      default: step_addr = 32'h0804_0000;
    endcase
  endfunction

  // value expected at a given arming step: alternating high/low magic
  function automatic logic [DATA_W-1:0] step_val(input logic [STEP_W-1:0] s);
    step_val = s[0] ? V_LO : V_HI;
  endfunction

  function automatic logic is_seq_addr(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < SEQ_LEN; i++)
      if (a == step_addr(STEP_W'(i))) hit = 1'b1;
    is_seq_addr = hit;
  endfunction

  function automatic logic is_decoded(input logic [ADDR_W-1:0] a);
    is_decoded = is_seq_addr(a) || (a == A_CLOSE) || (a == A_LOCK) ||
                 (a == A_ENABLE) || (a == A_GLOBAL);
  endfunction
endpackage

// File: rtl/unlock_seq.sv
module unlock_seq
  import gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              armed
);
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] step_nxt;

  // named internal events
  logic dec_wr, seq_hit, seq_done, restart_hit, close_hit;

  assign dec_wr      = wr_en && is_decoded(wr_addr);
  assign seq_hit     = dec_wr && (wr_addr == step_addr(step)) && (wr_data == step_val(step));
  assign seq_done    = seq_hit && (step == STEP_W'(SEQ_LEN - 1));
  assign restart_hit = dec_wr && (wr_addr == step_addr('0)) && (wr_data == step_val('0));
  assign close_hit   = dec_wr && (wr_addr == A_CLOSE) && (wr_data == V_LO);

  always_comb begin
    step_nxt = step;
    if (dec_wr) begin
      if (seq_hit)
        step_nxt = seq_done ? '0 : step + 1'b1;
      else if (restart_hit)
        step_nxt = STEP_W'(1);
      else
        step_nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step  <= '0;
      armed <= 1'b0;
    end else begin
      step <= step_nxt;
      if (seq_done)       armed <= 1'b1;
      else if (close_hit) armed <= 1'b0;
    end
  end

  assert_open_after_seq_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(seq_done));
  assert_close_shuts_R5: assert property (@(posedge clk) disable iff (rst)
    close_hit |=> !armed);
  assert_foreign_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !is_decoded(wr_addr)) |=> ($stable(step) && $stable(armed)));
  assert_mismatch_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_wr && !seq_hit && !restart_hit) |=> (step == '0));
  assert_reset_closed_R1: assert property (@(posedge clk)
    $past(rst) |-> (!armed && step == '0));
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import gate_pkg::*;
#(
  parameter int EN_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              armed,
  output logic              unlocked,
  output logic [EN_W-1:0]   en_bits,
  output logic              global_en
);
  logic reg_wr_ok, lock_wr, en_wr, gen_wr;

  assign reg_wr_ok = wr_en && armed;
  assign lock_wr   = reg_wr_ok && (wr_addr == A_LOCK);
  assign en_wr     = reg_wr_ok && (wr_addr == A_ENABLE);
  assign gen_wr    = reg_wr_ok && (wr_addr == A_GLOBAL) && (wr_data == V_GEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked  <= 1'b0;
      en_bits   <= '0;
      global_en <= 1'b0;
    end else begin
      if (lock_wr && wr_data == V_LO)      unlocked <= 1'b1;
      else if (lock_wr && wr_data == V_HI) unlocked <= 1'b0;
      if (en_wr)  en_bits   <= wr_data[EN_W-1:0];
      if (gen_wr) global_en <= 1'b1;
    end
  end

  assert_en_needs_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_bits) |-> ($past(armed) || $past(rst)));
  assert_lock_needs_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(unlocked) |-> ($past(armed) || $past(rst)));
  assert_gen_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(global_en) |-> $past(rst));
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!unlocked && en_bits == '0 && !global_en));
endmodule

// File: rtl/strobe_gate.sv
module strobe_gate #(
  parameter int NSTB = 3
) (
  input  logic            pass,
  input  logic [NSTB-1:0] stb_in,
  output logic [NSTB-1:0] stb_out
);
  for (genvar i = 0; i < NSTB; i++) begin : g_stb
    assign stb_out[i] = stb_in[i] & pass;
  end

  always_comb begin
    assert_stb_blocked_R9: assert (pass || stb_out == '0);
  end
endmodule

// File: rtl/magic_unlock_gate.sv
module magic_unlock_gate
  import gate_pkg::*;
#(
  parameter int NSTB = 3,
  parameter int EN_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NSTB-1:0]   host_stb,
  output logic              gate_open,
  output logic              flash_unlocked,
  output logic [EN_W-1:0]   en_bits,
  output logic              flash_ce_n,
  output logic              flash_wp_n,
  output logic              global_en,
  output logic [NSTB-1:0]   flash_stb
);
  unlock_seq u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .armed(gate_open)
  );

  ctrl_regs #(.EN_W(EN_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .armed(gate_open), .unlocked(flash_unlocked),
    .en_bits(en_bits), .global_en(global_en)
  );

  strobe_gate #(.NSTB(NSTB)) u_stb (
    .pass(flash_unlocked), .stb_in(host_stb), .stb_out(flash_stb)
  );

  assign flash_ce_n = en_bits[0];
  assign flash_wp_n = en_bits[EN_W-1];
endmodule

// File: tb/magic_unlock_gate_bench.sv
module magic_unlock_gate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  host_stb = '0;
  logic        gate_open, flash_unlocked, flash_ce_n, flash_wp_n, global_en;
  logic [1:0]  en_bits;
  logic [2:0]  flash_stb;

  magic_unlock_gate u_magic_unlock_gate (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .host_stb(host_stb), .gate_open(gate_open), .flash_unlocked(flash_unlocked),
    .en_bits(en_bits), .flash_ce_n(flash_ce_n), .flash_wp_n(flash_wp_n),
    .global_en(global_en), .flash_stb(flash_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  logic [31:0] key_a[$] = '{32'h09FE0000, 32'h08000000, 32'h08020000, 32'h08040000};
  logic [15:0] key_v[$] = '{16'hD200, 16'h1500, 16'hD200, 16'h1500};
  logic [31:0] known[$] = '{32'h09FE0000, 32'h08000000, 32'h08020000, 32'h08040000,
                            32'h09FC0000, 32'h09C40000, 32'h09400000, 32'h09880000};
  int   prog = 0;
  bit   m_open = 0, m_unl = 0, m_gen = 0;
  bit [1:0] m_en = 0;
  int   checks = 0, fails = 0;
  string cur_req = "R1";
  bit   done = 0;

  always @(posedge clk) begin
    if (rst) begin
      prog = 0; m_open = 0; m_unl = 0; m_gen = 0; m_en = 0;
    end else if (wr_en) begin
      bit known_hit;
      known_hit = 0;
      foreach (known[i]) if (known[i] == wr_addr) known_hit = 1;
      if (m_open) begin
        if (wr_addr == 32'h09C40000 && wr_data == 16'h1500) m_unl = 1;
        if (wr_addr == 32'h09C40000 && wr_data == 16'hD200) m_unl = 0;
        if (wr_addr == 32'h09400000) m_en = wr_data[1:0];
        if (wr_addr == 32'h09880000 && wr_data == 16'h8000) m_gen = 1;
      end
      if (known_hit) begin
        if (wr_addr == 32'h09FC0000 && wr_data == 16'h1500) m_open = 0;
        if (wr_addr == key_a[prog] && wr_data == key_v[prog]) begin
          prog = prog + 1;
          if (prog == 4) begin prog = 0; m_open = 1; end
        end else if (wr_addr == key_a[0] && wr_data == key_v[0]) prog = 1;
        else prog = 0;
      end
    end
  end

  always @(negedge clk) begin
    logic [2:0] exp_stb;
    if (!done) begin
      exp_stb = m_unl ? host_stb : 3'b000;
      checks++;
      if (gate_open !== m_open || flash_unlocked !== m_unl || en_bits !== m_en ||
          flash_ce_n !== m_en[0] || flash_wp_n !== m_en[1] || global_en !== m_gen ||
          flash_stb !== exp_stb) begin
        fails++;
        $display("FAIL %s: open=%b unl=%b en=%b ce_n=%b wp_n=%b gen=%b stb=%b expected open=%b unl=%b en=%b ce_n=%b wp_n=%b gen=%b stb=%b",
                 cur_req, gate_open, flash_unlocked, en_bits, flash_ce_n, flash_wp_n,
                 global_en, flash_stb, m_open, m_unl, m_en, m_en[0], m_en[1], m_gen, exp_stb);
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic arm();
    foreach (key_a[i]) wr(key_a[i], key_v[i]);
  endtask

  task automatic shut();
    wr(32'h09FC0000, 16'h1500);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cur_req = "R1"; idle(3); @(posedge clk); #2; rst = 0; idle(2);
    cur_req = "R10";
    wr(32'h09C40000, 16'h1500); wr(32'h09400000, 16'h0003); wr(32'h09880000, 16'h8000);
    cur_req = "R2"; arm(); idle(1);
    cur_req = "R6"; wr(32'h09C40000, 16'h1500);
    cur_req = "R5"; shut(); idle(1);
    cur_req = "R9";
    for (int s = 0; s < 8; s++) begin @(posedge clk); #2; host_stb = 3'(s); end
    cur_req = "R7";
    arm(); wr(32'h09400000, 16'h0001); shut();
    arm(); wr(32'h09400000, 16'h0003); shut();
    arm(); wr(32'h09400000, 16'h0000); shut();
    cur_req = "R8";
    arm(); wr(32'h09880000, 16'h1234); wr(32'h09880000, 16'h8000); shut();
    wr(32'h09880000, 16'h0000);
    cur_req = "R3";
    wr(32'h09FE0000, 16'hD200); wr(32'h08000000, 16'h1500); wr(32'h08020000, 16'h1234);
    wr(32'h08020000, 16'hD200); wr(32'h08040000, 16'h1500); idle(1);
    wr(32'h09FE0000, 16'hD200); wr(32'h09FE0000, 16'hD200); wr(32'h08000000, 16'h1500);
    wr(32'h08020000, 16'hD200); wr(32'h08040000, 16'h1500); idle(1); shut();
    wr(32'h09FE0000, 16'hD200); wr(32'h09400000, 16'h0002);
    wr(32'h08000000, 16'h1500); wr(32'h08020000, 16'hD200); wr(32'h08040000, 16'h1500);
    cur_req = "R4";
    wr(32'h09FE0000, 16'hD200); wr(32'h08001234, 16'h0000); wr(32'h08000000, 16'h1500);
    wr(32'h09FE0002, 16'hD200); wr(32'h08020000, 16'hD200); wr(32'h00000000, 16'hFFFF);
    wr(32'h08040000, 16'h1500); idle(1);
    wr(32'h09C40001, 16'hD200); wr(32'h09400004, 16'h0003);
    cur_req = "R5"; wr(32'h09FC0000, 16'hD200); wr(32'h09FC0000, 16'h0000); idle(1); shut();
    cur_req = "R6";
    arm(); wr(32'h09C40000, 16'h0001); wr(32'h09C40000, 16'hD200); shut();
    cur_req = "R9";
    for (int s = 0; s < 8; s++) begin @(posedge clk); #2; host_stb = 3'(7 - s); end
    cur_req = "R1";
    arm(); wr(32'h09C40000, 16'h1500); wr(32'h09400000, 16'h0003);
    @(posedge clk); #2; rst = 1; idle(2); rst = 0; idle(3);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule